// File: doc/BRIEF.md
# IDE Host Register Window

This block is the register front end of an IDE/ATA host controller on a 32-bit little-endian bus. Each bus access carries a byte count of 1, 2 or 4. The block decodes a 4 KiB address window into 16-byte register slots and checks the access size against what each slot accepts. Accepted accesses become single-cycle strobes on a simplified drive-side port: a data port, seven task-file registers, a status read and a device-control write. Accesses that are not accepted are dropped on write and answered with all ones on read.

The block also holds a 32-bit timing register and an interrupt state register. The interrupt state register mirrors the DMA-channel and disk interrupt lines in its two top bits, and software can acknowledge the DMA bit by writing a 1 to it. Both interrupt lines also pass straight through to their own output pins.

The bus side uses a valid/ready handshake. Read data comes back one cycle after the access is accepted, aligned to bit 0.

Top module: `ide_regwin`

## Requirements
- R1: The slot index is `req_addr >> 4`, so the low four address bits are ignored. An index with no register behind it returns 0xFFFFFFFF on read and has no effect on write.
- R2: Slot 0 is the data port and accepts byte counts 2 and 4. A 2-byte read returns `dev_data_rdata[15:0]` zero-extended, and a 4-byte read returns all 32 bits. An accepted access pulses `dev_data_rd` or `dev_data_wr`, and also pulses `dev_data_wide` when the byte count is 4. A 1-byte access raises no strobe.
- R3: Slots 1 to 7 are task-file registers and accept byte count 1 only. `dev_tf_sel` carries the low 3 bits of the slot index. A read returns `dev_tf_rdata` zero-extended.
- R4: Slots 0x08 and 0x16 both reach the same register and accept byte count 1 only. A read pulses `dev_stat_rd` and returns `dev_status` zero-extended. A write pulses `dev_ctl_wr`.
- R5: Slot 0x20 is a 32-bit timing register, read and written with byte count 4 only. Writes of any other size leave it unchanged.
- R6: Slot 0x30 is the interrupt state register, read with byte count 4. Bit 31 is the DMA bit and bit 30 is the disk bit; all other bits read 0. A bit is set on a rising edge of its line and cleared on a falling edge.
- R7: A 4-byte write to slot 0x30 with bit 31 set clears bit 31. No other written bit has an effect, and no other size has an effect. A rising edge of the DMA line in the same cycle as the clear takes priority, so the bit ends up set.
- R8: `dma_irq_out` follows `dma_irq_in` and `disk_irq_out` follows `disk_irq_in`, with no delay.
- R9: `req_ready` is low during reset and high afterwards. An accepted read raises `rsp_valid` for exactly the next cycle, with `rsp_rdata` holding the result. A write produces no response.
- R10: After reset, the timing register and the interrupt state register read 0, and all drive-side strobes stay low while reset is asserted.
- R11: A byte count that a slot does not accept, including 3 and any value other than 1, 2 or 4, reads 0xFFFFFFFF and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_size | input | 3 | Byte count: 1, 2 or 4 |
| req_wdata | input | DATA_W | Write data, aligned to bit 0 |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read response data |
| dev_data_rd | output | 1 | Data port read strobe |
| dev_data_wr | output | 1 | Data port write strobe |
| dev_data_wide | output | 1 | Data port access is 4 bytes |
| dev_data_rdata | input | DATA_W | Data port read value |
| dev_tf_rd | output | 1 | Task-file read strobe |
| dev_tf_wr | output | 1 | Task-file write strobe |
| dev_tf_sel | output | TF_SEL_W | Task-file register number |
| dev_tf_rdata | input | 8 | Task-file read value |
| dev_stat_rd | output | 1 | Status read strobe |
| dev_status | input | 8 | Drive status value |
| dev_ctl_wr | output | 1 | Device-control write strobe |
| dev_wdata | output | DATA_W | Write data toward the drive |
| dma_irq_in | input | 1 | DMA-channel interrupt line |
| disk_irq_in | input | 1 | Disk interrupt line |
| dma_irq_out | output | 1 | DMA interrupt output |
| disk_irq_out | output | 1 | Disk interrupt output |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 4-bit slot shift, task-file slots 1 to 7, status aliases at 0x08 and 0x16, timing at 0x20, interrupt state at 0x30, and only the DMA bit clearable. With these values, every decoded slot and the last slot of the window (0xFF0) can be reached with each legal and illegal byte count. That makes it possible to test the alias pair, the low-bit aliasing inside a slot, and the all-ones default. The interrupt lines are toggled directly, so the bench can observe set, clear, acknowledge and re-arm of the state bits.

// File: rtl/ide_regwin_pkg.sv
package ide_regwin_pkg;

   typedef enum logic [2:0] {
      SLOT_NONE,
      SLOT_DATA,
      SLOT_TF,
      SLOT_STAT,
      SLOT_TIMING,
      SLOT_IRQ
   } slot_e;

   typedef struct packed {
      logic data_rd;
      logic data_wr;
      logic data_wide;
      logic tf_rd;
      logic tf_wr;
      logic stat_rd;
      logic ctl_wr;
   } strobe_t;

   // Byte counts each slot accepts
   function automatic logic size_ok(input slot_e slot, input logic [2:0] size);
      case (slot)
         SLOT_DATA:   return (size == 3'd2) || (size == 3'd4);
         SLOT_TF:     return size == 3'd1;
         SLOT_STAT:   return size == 3'd1;
         SLOT_TIMING: return size == 3'd4;
         SLOT_IRQ:    return size == 3'd4;
         default:     return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ide_regwin_decode.sv
module ide_regwin_decode
   import ide_regwin_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int SLOT_SHIFT = 4,
   parameter int DATA_IDX   = 0,
   parameter int TF_FIRST   = 1,
   parameter int TF_LAST    = 7,
   parameter int TF_SEL_W   = 3,
   parameter int STAT_IDX_A = 8'h08,
   parameter int STAT_IDX_B = 8'h16,
   parameter int TIMING_IDX = 8'h20,
   parameter int IRQ_IDX    = 8'h30
) (
   input  logic                accept,
   input  logic                write,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2:0]          size,
   output slot_e               slot,
   output logic                allowed,
   output strobe_t             strb,
   output logic [TF_SEL_W-1:0] tf_sel
);
   localparam int IDX_W     = ADDR_W - SLOT_SHIFT;
   localparam int N_ALIAS   = 2;
   localparam int STAT_IDX [N_ALIAS] = '{STAT_IDX_A, STAT_IDX_B};

   logic [IDX_W-1:0]   idx;
   logic [N_ALIAS-1:0] stat_hit;
   logic               go_rd;
   logic               go_wr;

   assign idx = addr[ADDR_W-1:SLOT_SHIFT];

   // One comparator per status alias
   generate
      for (genvar a = 0; a < N_ALIAS; a++) begin : g_alias
         assign stat_hit[a] = (idx == IDX_W'(STAT_IDX[a]));
      end
   endgenerate

   always_comb begin
      slot = SLOT_NONE;
      if (idx == IDX_W'(DATA_IDX))
         slot = SLOT_DATA;
      else if ((idx >= IDX_W'(TF_FIRST)) && (idx <= IDX_W'(TF_LAST)))
         slot = SLOT_TF;
      else if (|stat_hit)
         slot = SLOT_STAT;
      else if (idx == IDX_W'(TIMING_IDX))
         slot = SLOT_TIMING;
      else if (idx == IDX_W'(IRQ_IDX))
         slot = SLOT_IRQ;
   end

   assign allowed = size_ok(slot, size);
   assign tf_sel  = TF_SEL_W'(idx);
   assign go_rd   = accept & allowed & ~write;
   assign go_wr   = accept & allowed & write;

   always_comb begin
      strb           = '0;
      strb.data_rd   = go_rd & (slot == SLOT_DATA);
      strb.data_wr   = go_wr & (slot == SLOT_DATA);
      strb.data_wide = accept & allowed & (slot == SLOT_DATA) & (size == 3'd4);
      strb.tf_rd     = go_rd & (slot == SLOT_TF);
      strb.tf_wr     = go_wr & (slot == SLOT_TF);
      strb.stat_rd   = go_rd & (slot == SLOT_STAT);
      strb.ctl_wr    = go_wr & (slot == SLOT_STAT);
   end

endmodule

// File: rtl/ide_regwin_irq.sv
module ide_regwin_irq #(
   parameter int                  NUM_LINES  = 2,
   parameter logic [NUM_LINES-1:0] CLEAR_MASK = 'b01
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   input  logic [NUM_LINES-1:0] clr,
   output logic [NUM_LINES-1:0] state,
   output logic [NUM_LINES-1:0] pass
);
   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
         logic prev_q;
         logic rise;
         logic fall;
         logic ack;

         assign rise = lines[n] & ~prev_q;
         assign fall = ~lines[n] & prev_q;

         // Only lines selected by CLEAR_MASK honour a software acknowledge
         if (CLEAR_MASK[n]) begin : g_ack
            assign ack = clr[n];
         end else begin : g_noack
            assign ack = 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q   <= 1'b0;
               state[n] <= 1'b0;
            end else begin
               prev_q <= lines[n];
               if (rise)
                  state[n] <= 1'b1;
               else if (fall || ack)
                  state[n] <= 1'b0;
            end
         end

         assign pass[n] = lines[n];
      end
   endgenerate

endmodule

// File: rtl/ide_regwin_rsp.sv
module ide_regwin_rsp
   import ide_regwin_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter logic [31:0] DEFAULT_RD = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              write,
   input  slot_e             slot,
   input  logic              allowed,
   input  logic [2:0]        size,
   input  logic [DATA_W-1:0] data_rdata,
   input  logic [7:0]        tf_rdata,
   input  logic [7:0]        status,
   input  logic [DATA_W-1:0] timing,
   input  logic [DATA_W-1:0] irq_val,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = DATA_W'(DEFAULT_RD);
      if (allowed) begin
         case (slot)
            SLOT_DATA:   rd_mux = (size == 3'd4) ? data_rdata
                                                 : DATA_W'(data_rdata[15:0]);
            SLOT_TF:     rd_mux = DATA_W'(tf_rdata);
            SLOT_STAT:   rd_mux = DATA_W'(status);
            SLOT_TIMING: rd_mux = timing;
            SLOT_IRQ:    rd_mux = irq_val;
            default:     rd_mux = DATA_W'(DEFAULT_RD);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= accept & ~write;
         if (accept && !write)
            rsp_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/ide_regwin.sv
module ide_regwin
   import ide_regwin_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          SLOT_SHIFT = 4,
   parameter int          TF_FIRST   = 1,
   parameter int          TF_LAST    = 7,
   parameter int          TF_SEL_W   = 3,
   parameter int          STAT_IDX_A = 8'h08,
   parameter int          STAT_IDX_B = 8'h16,
   parameter int          TIMING_IDX = 8'h20,
   parameter int          IRQ_IDX    = 8'h30,
   parameter logic [1:0]  IRQ_CLEAR  = 2'b01,
   parameter logic [31:0] DEFAULT_RD = 32'hFFFF_FFFF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2:0]          req_size,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                dev_data_rd,
   output logic                dev_data_wr,
   output logic                dev_data_wide,
   input  logic [DATA_W-1:0]   dev_data_rdata,
   output logic                dev_tf_rd,
   output logic                dev_tf_wr,
   output logic [TF_SEL_W-1:0] dev_tf_sel,
   input  logic [7:0]          dev_tf_rdata,
   output logic                dev_stat_rd,
   input  logic [7:0]          dev_status,
   output logic                dev_ctl_wr,
   output logic [DATA_W-1:0]   dev_wdata,
   input  logic                dma_irq_in,
   input  logic                disk_irq_in,
   output logic                dma_irq_out,
   output logic                disk_irq_out
);
   localparam int NUM_IRQ = 2;
   localparam int IDX_W   = ADDR_W - SLOT_SHIFT;

   // Elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("ide_regwin: DATA_W must be 32");
      end
      if (IDX_W < 1 || IRQ_IDX >= (1 << IDX_W) || TIMING_IDX >= (1 << IDX_W)) begin : g_bad_idx
         $error("ide_regwin: slot index does not fit the window");
      end
      if (TF_LAST >= (1 << TF_SEL_W) || TF_FIRST > TF_LAST) begin : g_bad_tf
         $error("ide_regwin: task-file range does not fit TF_SEL_W");
      end
   endgenerate

   slot_e                slot;
   logic                 allowed;
   strobe_t              strb;
   logic                 accept;
   logic [DATA_W-1:0]    timing_q;
   logic [NUM_IRQ-1:0]   irq_lines;
   logic [NUM_IRQ-1:0]   irq_clr;
   logic [NUM_IRQ-1:0]   irq_state;
   logic [NUM_IRQ-1:0]   irq_pass;
   logic [DATA_W-1:0]    irq_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_ready <= 1'b0;
      else        req_ready <= 1'b1;
   end

   assign accept = req_valid & req_ready;

   ide_regwin_decode #(
      .ADDR_W    (ADDR_W),
      .SLOT_SHIFT(SLOT_SHIFT),
      .DATA_IDX  (0),
      .TF_FIRST  (TF_FIRST),
      .TF_LAST   (TF_LAST),
      .TF_SEL_W  (TF_SEL_W),
      .STAT_IDX_A(STAT_IDX_A),
      .STAT_IDX_B(STAT_IDX_B),
      .TIMING_IDX(TIMING_IDX),
      .IRQ_IDX   (IRQ_IDX)
   ) u_decode (
      .accept (accept),
      .write  (req_write),
      .addr   (req_addr),
      .size   (req_size),
      .slot   (slot),
      .allowed(allowed),
      .strb   (strb),
      .tf_sel (dev_tf_sel)
   );

   assign dev_data_rd   = strb.data_rd;
   assign dev_data_wr   = strb.data_wr;
   assign dev_data_wide = strb.data_wide;
   assign dev_tf_rd     = strb.tf_rd;
   assign dev_tf_wr     = strb.tf_wr;
   assign dev_stat_rd   = strb.stat_rd;
   assign dev_ctl_wr    = strb.ctl_wr;
   assign dev_wdata     = req_wdata;

   // Timing register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         timing_q <= '0;
      else if (accept && req_write && allowed && slot == SLOT_TIMING)
         timing_q <= req_wdata;
   end

   // Interrupt line n owns bit DATA_W-1-n: line 0 is DMA, line 1 is disk
   assign irq_lines = {disk_irq_in, dma_irq_in};

   generate
      for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq_bit
         assign irq_clr[n] = accept & req_write & allowed & (slot == SLOT_IRQ)
                           & req_wdata[DATA_W-1-n];
      end
   endgenerate

   always_comb begin
      irq_val = '0;
      for (int n = 0; n < NUM_IRQ; n++)
         irq_val[DATA_W-1-n] = irq_state[n];
   end

   ide_regwin_irq #(
      .NUM_LINES (NUM_IRQ),
      .CLEAR_MASK(IRQ_CLEAR)
   ) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .lines(irq_lines),
      .clr  (irq_clr),
      .state(irq_state),
      .pass (irq_pass)
   );

   assign dma_irq_out  = irq_pass[0];
   assign disk_irq_out = irq_pass[1];

   ide_regwin_rsp #(
      .DATA_W    (DATA_W),
      .DEFAULT_RD(DEFAULT_RD)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .write     (req_write),
      .slot      (slot),
      .allowed   (allowed),
      .size      (req_size),
      .data_rdata(dev_data_rdata),
      .tf_rdata  (dev_tf_rdata),
      .status    (dev_status),
      .timing    (timing_q),
      .irq_val   (irq_val),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/ide_regwin_chk.sv
module ide_regwin_chk #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int SLOT_SHIFT = 4,
   parameter int TIMING_IDX = 8'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [2:0]        req_size,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [6:0]        strobes,
   input logic              dma_irq_in,
   input logic              disk_irq_in,
   input logic              dma_irq_out,
   input logic              disk_irq_out,
   input logic [1:0]        irq_state,
   input logic [DATA_W-1:0] timing_q
);
   logic acc;
   logic timing_wr;
   assign acc       = req_valid & req_ready;
   assign timing_wr = acc & req_write & (req_size == 3'd4)
                    & (req_addr[ADDR_W-1:SLOT_SHIFT] == (ADDR_W-SLOT_SHIFT)'(TIMING_IDX));

   // R9: a read is answered in the next cycle
   assert_read_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write) |=> rsp_valid);

   // R9: no response without an accepted read
   assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && !req_write) |=> !rsp_valid);

   // R1: at most one drive-side operation strobe per cycle (wide flag excluded)
   assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobes[6:5], strobes[3:0]}));

   // R8: interrupt outputs follow their lines
   assert_irq_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_irq_out == dma_irq_in) && (disk_irq_out == disk_irq_in));

   // R6/R7: a rising line sets its state bit, even against an acknowledge
   assert_dma_rise_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_irq_in) |=> irq_state[0]);

   assert_disk_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disk_irq_in) |=> irq_state[1]);

   // R6: a falling line clears its state bit
   assert_dma_fall_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_irq_in) |=> !irq_state[0]);

   assert_disk_fall_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disk_irq_in) |=> !irq_state[1]);

   // R5: a 4-byte write to the timing slot lands in the register
   assert_timing_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      timing_wr |=> (timing_q == $past(req_wdata)));

   // R10: strobes are quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (strobes == 7'd0 && !req_ready);
      end
   end

endmodule

bind ide_regwin ide_regwin_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .req_size    (req_size),
   .req_wdata   (req_wdata),
   .rsp_valid   (rsp_valid),
   .strobes     ({dev_data_rd, dev_data_wr, dev_data_wide, dev_tf_rd,
                  dev_tf_wr, dev_stat_rd, dev_ctl_wr}),
   .dma_irq_in  (dma_irq_in),
   .disk_irq_in (disk_irq_in),
   .dma_irq_out (dma_irq_out),
   .disk_irq_out(disk_irq_out),
   .irq_state   (irq_state),
   .timing_q    (timing_q)
);

// File: tb/test_ide_regwin.sv
`timescale 1ns/1ps
module test_ide_regwin;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        dev_data_rd, dev_data_wr, dev_data_wide;
   logic        dev_tf_rd, dev_tf_wr, dev_stat_rd, dev_ctl_wr;
   logic [2:0]  dev_tf_sel;
   logic [31:0] dev_wdata;
   logic        dma_irq_in = 1'b0;
   logic        disk_irq_in = 1'b0;
   logic        dma_irq_out, disk_irq_out;

   // Drive-side model
   logic [31:0] dev_data_rdata;
   logic [7:0]  dev_tf_rdata;
   logic [7:0]  dev_status;
   assign dev_data_rdata = 32'hA5C3_1E72;
   assign dev_tf_rdata   = {5'b01000, dev_tf_sel};
   assign dev_status     = 8'h58;

   always #10 clk = ~clk;

   ide_regwin i_ide_regwin (.*);

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   // Strobe bits: {data_rd, data_wr, data_wide, tf_rd, tf_wr, stat_rd, ctl_wr}
   localparam logic [6:0] S0 = 7'b0000000, SDR = 7'b1000000, SDW = 7'b0100000,
                          SWD = 7'b0010000, STR = 7'b0001000, STW = 7'b0000100,
                          SSR = 7'b0000010, SCW = 7'b0000001;
   localparam logic [31:0] ONES = 32'hFFFF_FFFF;

   // {req[3:0], wr, addr[11:0], size[2:0], wdata[31:0], exp_rd[31:0], strb[6:0]}
   localparam int NV = 23;
   localparam logic [90:0] VEC [NV] = '{
      {4'd2,  1'b0, 12'h000, 3'd2, 32'h0,         32'h0000_1E72, SDR},       // R2
      {4'd2,  1'b0, 12'h004, 3'd4, 32'h0,         32'hA5C3_1E72, SDR|SWD},   // R2 R1
      {4'd2,  1'b0, 12'h000, 3'd1, 32'h0,         ONES,          S0},        // R2
      {4'd3,  1'b0, 12'h010, 3'd1, 32'h0,         32'h0000_0041, STR},       // R3
      {4'd3,  1'b0, 12'h07F, 3'd1, 32'h0,         32'h0000_0047, STR},       // R3 R1
      {4'd11, 1'b0, 12'h030, 3'd4, 32'h0,         ONES,          S0},        // R11
      {4'd4,  1'b0, 12'h080, 3'd1, 32'h0,         32'h0000_0058, SSR},       // R4
      {4'd4,  1'b0, 12'h160, 3'd1, 32'h0,         32'h0000_0058, SSR},       // R4
      {4'd1,  1'b0, 12'h090, 3'd1, 32'h0,         ONES,          S0},        // R1
      {4'd2,  1'b1, 12'h000, 3'd4, 32'h1111_2222, 32'h0,         SDW|SWD},   // R2
      {4'd2,  1'b1, 12'h000, 3'd2, 32'h0000_3333, 32'h0,         SDW},       // R2
      {4'd2,  1'b1, 12'h000, 3'd1, 32'h0000_0044, 32'h0,         S0},        // R2
      {4'd3,  1'b1, 12'h050, 3'd1, 32'h0000_0055, 32'h0,         STW},       // R3
      {4'd11, 1'b1, 12'h050, 3'd2, 32'h0000_0055, 32'h0,         S0},        // R11
      {4'd4,  1'b1, 12'h160, 3'd1, 32'h0000_0002, 32'h0,         SCW},       // R4
      {4'd5,  1'b1, 12'h200, 3'd4, 32'h1234_ABCD, 32'h0,         S0},        // R5
      {4'd5,  1'b0, 12'h200, 3'd4, 32'h0,         32'h1234_ABCD, S0},        // R5
      {4'd11, 1'b0, 12'h200, 3'd2, 32'h0,         ONES,          S0},        // R11
      {4'd5,  1'b1, 12'h20C, 3'd1, 32'h0000_0000, 32'h0,         S0},        // R5
      {4'd5,  1'b0, 12'h200, 3'd4, 32'h0,         32'h1234_ABCD, S0},        // R5
      {4'd6,  1'b0, 12'h300, 3'd4, 32'h0,         32'h0,         S0},        // R6
      {4'd1,  1'b0, 12'hFF0, 3'd4, 32'h0,         ONES,          S0},        // R1
      {4'd11, 1'b0, 12'h000, 3'd3, 32'h0,         ONES,          S0}         // R11
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [11:0] addr, input logic [2:0] size,
                         input logic [31:0] wdata, output logic [6:0] strb,
                         output logic [31:0] rd, output logic rv);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = addr;
      req_size  = size;
      req_wdata = wdata;
      #2;
      strb = {dev_data_rd, dev_data_wr, dev_data_wide, dev_tf_rd,
              dev_tf_wr, dev_stat_rd, dev_ctl_wr};
      @(negedge clk);
      req_valid = 1'b0;
      rv = rsp_valid;
      rd = rsp_rdata;
   endtask

   logic [6:0]  s;
   logic [31:0] d;
   logic        v;

   initial begin
      // R10 / R9: behaviour under reset
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h010; req_size = 3'd1;
      #2;
      chk("R10 strobes in reset", 32'({dev_data_rd, dev_data_wr, dev_tf_rd, dev_tf_wr,
                                      dev_stat_rd, dev_ctl_wr}), 32'd0);
      chk("R9 ready in reset", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("R9 no response in reset", 32'(rsp_valid), 32'd0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready after reset", 32'(req_ready), 32'd1);

      access(1'b0, 12'h200, 3'd4, 32'h0, s, d, v);
      chk("R10 timing after reset", d, 32'h0);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R10 irq state after reset", d, 32'h0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         automatic logic [90:0] vv = VEC[i];
         automatic logic [3:0]  rq = vv[90:87];
         automatic logic        wr = vv[86];
         access(wr, vv[85:74], vv[73:71], vv[70:39], s, d, v);
         chk($sformatf("R%0d vector %0d strobes", rq, i), 32'(s), 32'(vv[6:0]));
         if (wr) begin
            chk($sformatf("R9 vector %0d write response", i), 32'(v), 32'd0);
         end else begin
            chk($sformatf("R9 vector %0d read response", i), 32'(v), 32'd1);
            chk($sformatf("R%0d vector %0d rdata", rq, i), d, vv[38:7]);
         end
      end

      // R3: register number on the task-file select
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h05A; req_size = 3'd1;
      req_wdata = 32'h0000_00A7;
      #2;
      chk("R3 tf_sel", 32'(dev_tf_sel), 32'd5);
      chk("R3 wdata forwarded", dev_wdata, 32'h0000_00A7);
      @(negedge clk);
      req_valid = 1'b0;

      // R8 / R6 / R7: interrupt lines and state register
      @(negedge clk);
      dma_irq_in = 1'b1;
      #1;
      chk("R8 dma out", 32'(dma_irq_out), 32'd1);
      chk("R8 disk out", 32'(disk_irq_out), 32'd0);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R6 dma bit set", d, 32'h8000_0000);
      @(negedge clk);
      disk_irq_in = 1'b1;
      #1;
      chk("R8 disk out high", 32'(disk_irq_out), 32'd1);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R6 both bits set", d, 32'hC000_0000);
      access(1'b1, 12'h300, 3'd2, 32'h8000_0000, s, d, v);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R7 2-byte clear ignored", d, 32'hC000_0000);
      access(1'b1, 12'h300, 3'd4, 32'h7FFF_FFFF, s, d, v);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R7 other bits ignored", d, 32'hC000_0000);
      access(1'b1, 12'h300, 3'd4, 32'h8000_0000, s, d, v);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R7 dma bit acknowledged", d, 32'h4000_0000);
      @(negedge clk); dma_irq_in = 1'b0;
      @(negedge clk); dma_irq_in = 1'b1;
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R6 dma bit re-armed", d, 32'hC000_0000);
      @(negedge clk); disk_irq_in = 1'b0;
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R6 disk bit cleared by fall", d, 32'h8000_0000);
      @(negedge clk); dma_irq_in = 1'b0;
      #1;
      chk("R8 dma out low", 32'(dma_irq_out), 32'd0);
      access(1'b0, 12'h300, 3'd4, 32'h0, s, d, v);
      chk("R6 dma bit cleared by fall", d, 32'h0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule